// File: doc/BRIEF.md
# Paged Address Translator with Page Status Tracking

This block turns a 24-bit CPU address into a physical address. The lower 4 MB of the address space is split into 1024 pages of 4 KB. Each page has one 16-bit entry in an internal map store. For an address inside that window, the block takes the physical page number from the entry and joins it to the in-page offset. An address at or above 0x400000 passes through unchanged.

Every strobed access inside the window also updates a two-bit status field in the entry. The update tracks whether the page is untouched, has been read, or has been written. The read-modify-write happens in the same cycle as the translation, and the new entry is stored at the next clock edge. An access to a page marked not present raises a flag and leaves the entry as it was.

A separate map port lets the CPU read any entry and write any entry. A CPU write wins over a status update to the same entry in the same cycle.

Top module: `pxl_translator`

## Requirements
- R1: After reset every map entry reads back as 0x0000, so every page starts not present.
- R2: When xl_addr is at or above 0x400000 (bits [23:22] not both zero), xl_paddr equals xl_addr, xl_absent is 0, and no entry changes.
- R3: When xl_addr is below 0x400000, xl_paddr is {2'b00, entry[9:0], xl_addr[11:0]}, where entry is the map word selected by page index xl_addr[21:12]. This holds in the same cycle, whether or not xl_valid is high.
- R4: The status field is entry bits [14:13], coded 0 not present, 1 present and untouched, 2 read, 3 written. A strobed read of a status-1 page changes it to 2, and a strobed write changes it to 3.
- R5: A strobed write to a status-2 page changes it to 3. A strobed read of a status-2 page leaves it at 2. A status-3 page stays at 3 for reads and writes alike.
- R6: A status update keeps entry bit 15 (page write enable) and bits [12:0] at their old values.
- R7: With xl_valid high and xl_addr inside the window, a status-0 page drives xl_absent to 1 in the same cycle and its entry stays unchanged. In every other case xl_absent is 0.
- R8: The updated entry is in place after the clock edge that ends the access. Both the next translation and a map-port read see it.
- R9: If mp_we targets the same entry as a strobed translation in the same cycle, the entry takes mp_wdata. The translation still uses the old entry for xl_paddr and xl_absent.
- R10: mp_rdata shows the entry selected by mp_idx without delay. When mp_we is high, mp_wdata is stored at the rising edge.
- R11: With xl_valid low, no entry changes, whatever xl_addr and xl_write hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| xl_valid | input | 1 | Access strobe; enables the status update and the absent flag |
| xl_write | input | 1 | Access is a write (1) or a read (0) |
| xl_addr | input | 24 | Logical CPU address |
| xl_paddr | output | 24 | Translated or passed-through address |
| xl_absent | output | 1 | Strobed access hit a not-present page |
| mp_we | input | 1 | Map-port write strobe |
| mp_idx | input | 10 | Map-port entry index |
| mp_wdata | input | 16 | Map-port write data |
| mp_rdata | output | 16 | Entry selected by mp_idx |

## Verification
The assertions assume that map-port writes and translations use the documented index fields, and that inputs stay stable around each rising edge. The status-tracking properties also assume that mp_idx still points at a page one cycle after it was accessed. Each of those properties is written as an implication that holds trivially when mp_idx has moved on.

The stimulus drives every input at the falling edge. It keeps most page indices and mp_idx within the first 16 entries. That concentration produces frequent same-page collisions, repeated status transitions, and map-port reads that follow up on the page just accessed.

// File: rtl/pxl_pkg.sv
package pxl_pkg;

  typedef enum logic [1:0] {
    PG_ABSENT = 2'd0,
    PG_FRESH  = 2'd1,
    PG_READ   = 2'd2,
    PG_DIRTY  = 2'd3
  } pg_state_e;

  // bit position of the two-bit status field inside a map entry
  localparam int unsigned ST_LSB = 13;

  function automatic pg_state_e pg_next(input pg_state_e cur, input logic is_wr);
    pg_state_e nxt;
    nxt = cur;
    unique case (cur)
      PG_ABSENT: nxt = PG_ABSENT;
      PG_FRESH:  nxt = is_wr ? PG_DIRTY : PG_READ;
      PG_READ:   nxt = is_wr ? PG_DIRTY : PG_READ;
      PG_DIRTY:  nxt = PG_DIRTY;
      default:   nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/pxl_addr_split.sv
module pxl_addr_split #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned PPN_W  = 10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [PPN_W-1:0]  ppn,
  output logic              in_win,
  output logic [IDX_W-1:0]  page_idx,
  output logic [ADDR_W-1:0] paddr
);

  localparam int unsigned WIN_LSB = IDX_W + OFF_W;
  localparam int unsigned PAD_W   = ADDR_W - PPN_W - OFF_W;

  logic [OFF_W-1:0] offset;

  always_comb begin
    in_win   = (addr[ADDR_W-1:WIN_LSB] == '0);
    page_idx = addr[WIN_LSB-1:OFF_W];
    offset   = addr[OFF_W-1:0];
    if (in_win) begin
      paddr = {{PAD_W{1'b0}}, ppn, offset};
    end else begin
      paddr = addr;
    end
  end

endmodule

// File: rtl/pxl_status_upd.sv
module pxl_status_upd #(
  parameter int unsigned ENT_W = 16
) (
  input  logic [ENT_W-1:0] entry_old,
  input  logic             is_wr,
  output logic [ENT_W-1:0] entry_new,
  output logic             changed,
  output logic             absent
);
  import pxl_pkg::*;

  pg_state_e cur_st;
  pg_state_e nxt_st;

  always_comb begin
    cur_st    = pg_state_e'(entry_old[ST_LSB +: 2]);
    nxt_st    = pg_next(cur_st, is_wr);
    entry_new = entry_old;
    entry_new[ST_LSB +: 2] = nxt_st;
    changed   = (nxt_st != cur_st);
    absent    = (cur_st == PG_ABSENT);
  end

endmodule

// File: rtl/pxl_map_store.sv
module pxl_map_store #(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned ENT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_we,
  input  logic [IDX_W-1:0] cpu_idx,
  input  logic [ENT_W-1:0] cpu_wdata,
  input  logic             upd_we,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [ENT_W-1:0] upd_wdata,
  input  logic [IDX_W-1:0] rda_idx,
  output logic [ENT_W-1:0] rda_data,
  input  logic [IDX_W-1:0] rdb_idx,
  output logic [ENT_W-1:0] rdb_data
);

  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DEPTH*ENT_W-1:0] flat;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic             cpu_hit;
    logic             upd_hit;
    logic             en;
    logic [ENT_W-1:0] d;
    logic [ENT_W-1:0] q;

    always_comb begin
      cpu_hit = cpu_we && (cpu_idx == IDX_W'(g));
      upd_hit = upd_we && (upd_idx == IDX_W'(g));
      en      = cpu_hit || upd_hit;
      d       = cpu_hit ? cpu_wdata : upd_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (en) begin
        q <= d;
      end
    end

    assign flat[g*ENT_W +: ENT_W] = q;
  end

  assign rda_data = flat[rda_idx*ENT_W +: ENT_W];
  assign rdb_data = flat[rdb_idx*ENT_W +: ENT_W];

endmodule

// File: rtl/pxl_translator.sv
module pxl_translator #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned ENT_W  = 16,
  parameter int unsigned PPN_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xl_valid,
  input  logic              xl_write,
  input  logic [ADDR_W-1:0] xl_addr,
  output logic [ADDR_W-1:0] xl_paddr,
  output logic              xl_absent,
  input  logic              mp_we,
  input  logic [IDX_W-1:0]  mp_idx,
  input  logic [ENT_W-1:0]  mp_wdata,
  output logic [ENT_W-1:0]  mp_rdata
);

  logic [1:0]       rst_sync;
  logic             rst_q;
  logic             in_win;
  logic [IDX_W-1:0] page_idx;
  logic [ENT_W-1:0] xl_entry;
  logic [ENT_W-1:0] xl_entry_new;
  logic             st_changed;
  logic             st_absent;
  logic             upd_we;

  // reset: asserted asynchronously, released on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_q = rst_sync[1];

  pxl_addr_split #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .PPN_W(PPN_W)
  ) u_split (
    .addr    (xl_addr),
    .ppn     (xl_entry[PPN_W-1:0]),
    .in_win  (in_win),
    .page_idx(page_idx),
    .paddr   (xl_paddr)
  );

  pxl_status_upd #(.ENT_W(ENT_W)) u_upd (
    .entry_old(xl_entry),
    .is_wr    (xl_write),
    .entry_new(xl_entry_new),
    .changed  (st_changed),
    .absent   (st_absent)
  );

  always_comb begin
    upd_we    = xl_valid && in_win && st_changed;
    xl_absent = xl_valid && in_win && st_absent;
  end

  pxl_map_store #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_q),
    .cpu_we   (mp_we),
    .cpu_idx  (mp_idx),
    .cpu_wdata(mp_wdata),
    .upd_we   (upd_we),
    .upd_idx  (page_idx),
    .upd_wdata(xl_entry_new),
    .rda_idx  (page_idx),
    .rda_data (xl_entry),
    .rdb_idx  (mp_idx),
    .rdb_data (mp_rdata)
  );

endmodule

// File: rtl/pxl_checker.sv
module pxl_checker #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned ENT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xl_valid,
  input logic              xl_write,
  input logic [ADDR_W-1:0] xl_addr,
  input logic [ADDR_W-1:0] xl_paddr,
  input logic              xl_absent,
  input logic              mp_we,
  input logic [IDX_W-1:0]  mp_idx,
  input logic [ENT_W-1:0]  mp_wdata,
  input logic [ENT_W-1:0]  mp_rdata,
  input logic [ENT_W-1:0]  cur_entry
);

  localparam int unsigned WIN_LSB = IDX_W + OFF_W;

  logic             win;
  logic [IDX_W-1:0] pg;
  logic             clash;
  logic [1:0]       st;

  assign win   = (xl_addr[ADDR_W-1:WIN_LSB] == '0);
  assign pg    = xl_addr[WIN_LSB-1:OFF_W];
  assign clash = mp_we && (mp_idx == pg);
  assign st    = cur_entry[14:13];

  a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    !win |-> (xl_paddr == xl_addr) && !xl_absent);

  a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    win |-> xl_paddr[OFF_W-1:0] == xl_addr[OFF_W-1:0]);

  a_r7_absent_scope: assert property (@(posedge clk) disable iff (!rst_n)
    xl_absent |-> xl_valid && win);

  a_r4_fresh_read: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid && win && !xl_write && st == 2'd1 && !clash
    |=> (mp_idx != $past(pg)) || (mp_rdata[14:13] == 2'd2));

  a_r5_write_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid && win && xl_write && st != 2'd0 && !clash
    |=> (mp_idx != $past(pg)) || (mp_rdata[14:13] == 2'd3));

  a_r6_we_kept: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid && win && !clash
    |=> (mp_idx != $past(pg)) || (mp_rdata[15] == $past(cur_entry[15])));

  a_r7_absent_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    xl_absent && !clash
    |=> (mp_idx != $past(pg)) || (mp_rdata == $past(cur_entry)));

  a_r9_cpu_wins: assert property (@(posedge clk) disable iff (!rst_n)
    mp_we |=> (mp_idx != $past(mp_idx)) || (mp_rdata == $past(mp_wdata)));

endmodule

bind pxl_translator pxl_checker #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .ENT_W(ENT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_q),
  .xl_valid (xl_valid),
  .xl_write (xl_write),
  .xl_addr  (xl_addr),
  .xl_paddr (xl_paddr),
  .xl_absent(xl_absent),
  .mp_we    (mp_we),
  .mp_idx   (mp_idx),
  .mp_wdata (mp_wdata),
  .mp_rdata (mp_rdata),
  .cur_entry(xl_entry)
);

// File: tb/pxl_translator_bench.sv
`timescale 1ns/1ps
module pxl_translator_bench;

  logic        clk;
  logic        rst_n;
  logic        xl_valid;
  logic        xl_write;
  logic [23:0] xl_addr;
  logic [23:0] xl_paddr;
  logic        xl_absent;
  logic        mp_we;
  logic [9:0]  mp_idx;
  logic [15:0] mp_wdata;
  logic [15:0] mp_rdata;

  logic [15:0] mdl [1024];
  int unsigned n_chk;
  int unsigned n_bad;
  bit          done;

  pxl_translator u_pxl_translator (
    .clk(clk), .rst_n(rst_n),
    .xl_valid(xl_valid), .xl_write(xl_write), .xl_addr(xl_addr),
    .xl_paddr(xl_paddr), .xl_absent(xl_absent),
    .mp_we(mp_we), .mp_idx(mp_idx), .mp_wdata(mp_wdata), .mp_rdata(mp_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [15:0] exp_entry(input logic [15:0] e, input logic wr);
    logic [15:0] r;
    r = e;
    case (e[14:13])
      2'd1: r[14:13] = wr ? 2'd3 : 2'd2;
      2'd2: r[14:13] = wr ? 2'd3 : 2'd2;
      default: r = e;
    endcase
    return r;
  endfunction

  function automatic logic [23:0] exp_paddr(input logic [23:0] a, input logic [15:0] e);
    return (a[23:22] == 2'b00) ? {2'b00, e[9:0], a[11:0]} : a;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one cycle: drive at falling edge, check before rising edge, update model after it
  task automatic step(input logic v, input logic w, input logic [23:0] a,
                      input logic mw, input logic [9:0] mi, input logic [15:0] md,
                      input string req);
    logic        inw;
    logic [9:0]  pg;
    logic [15:0] e;
    @(negedge clk);
    xl_valid = v; xl_write = w; xl_addr = a;
    mp_we = mw; mp_idx = mi; mp_wdata = md;
    #1;
    inw = (a[23:22] == 2'b00);
    pg  = a[21:12];
    e   = mdl[pg];
    chk({req, " paddr"}, 32'(xl_paddr), 32'(exp_paddr(a, e)));
    chk({req, " absent"}, 32'(xl_absent), 32'(v && inw && e[14:13] == 2'd0));
    chk({req, " R10 rdata"}, 32'(mp_rdata), 32'(mdl[mi]));
    @(posedge clk);
    if (v && inw) mdl[pg] = exp_entry(e, w);
    if (mw) mdl[mi] = md;
  endtask

  task automatic peek(input logic [9:0] i, input logic [15:0] exp, input string req);
    @(negedge clk);
    xl_valid = 1'b0; mp_we = 1'b0; mp_idx = i;
    #1;
    chk(req, 32'(mp_rdata), 32'(exp));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    n_chk = 0; n_bad = 0; done = 1'b0;
    for (int i = 0; i < 1024; i++) mdl[i] = 16'h0000;
    rst_n = 1'b0; xl_valid = 1'b0; xl_write = 1'b0; xl_addr = '0;
    mp_we = 1'b0; mp_idx = '0; mp_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset contents
    peek(10'd0, 16'h0000, "R1 reset entry 0");
    peek(10'd513, 16'h0000, "R1 reset entry 513");
    peek(10'd1023, 16'h0000, "R1 reset entry 1023");

    // R7: absent page, entry frozen
    step(1, 0, 24'h005ABC, 0, 10'd5, 16'h0, "R7 absent read");
    peek(10'd5, 16'h0000, "R7 entry unchanged");

    // R10 / R3 / R4 / R6
    step(0, 0, 24'h0, 1, 10'd3, 16'hA155, "R10 cpu write");
    peek(10'd3, 16'hA155, "R10 stored");
    step(0, 1, 24'h003777, 0, 10'd3, 16'h0, "R11 no strobe");
    peek(10'd3, 16'hA155, "R11 entry unchanged");
    step(1, 0, 24'h003ABC, 0, 10'd3, 16'h0, "R3 R4 read fresh");
    peek(10'd3, 16'hC155, "R4 R6 read to accessed");
    step(1, 0, 24'h003001, 0, 10'd3, 16'h0, "R5 read stays");
    peek(10'd3, 16'hC155, "R5 read keeps accessed");
    step(1, 1, 24'h003002, 0, 10'd3, 16'h0, "R5 write accessed");
    peek(10'd3, 16'hE155, "R5 R6 dirty");
    step(0, 0, 24'h0, 1, 10'd4, 16'h3FFF, "R10 fresh no-we");
    step(1, 1, 24'h004FFF, 0, 10'd4, 16'h0, "R4 write fresh");
    peek(10'd4, 16'h7FFF, "R4 R6 fresh to dirty keeps low bits");
    step(1, 0, 24'h004000, 0, 10'd4, 16'h0, "R8 next access sees update");

    // R2: pass-through
    step(1, 1, 24'h400123, 0, 10'd0, 16'h0, "R2 just above window");
    step(1, 0, 24'hFFFFFF, 0, 10'd0, 16'h0, "R2 top of space");
    peek(10'd0, 16'h0000, "R2 no update");

    // R9: collision
    step(0, 0, 24'h0, 1, 10'd7, 16'h2ABC, "R9 setup");
    step(1, 0, 24'h007010, 1, 10'd7, 16'h8123, "R9 collide uses old");
    peek(10'd7, 16'h8123, "R9 cpu value wins");

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      logic        v;
      logic        w;
      logic        mw;
      logic [23:0] a;
      logic [9:0]  mi;
      logic [15:0] md;
      v  = ($urandom % 4) != 0;
      w  = $urandom % 2;
      if (($urandom % 5) != 0)
        a = {2'b00, 6'b0, 4'($urandom), 12'($urandom)};
      else
        a = 24'($urandom);
      mw = ($urandom % 6) == 0;
      mi = 10'($urandom % 16);
      md = 16'($urandom);
      step(v, w, a, mw, mi, md, "R8 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule